// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block holds the instruction fetch address of a small single-issue core with a 13-bit program space. In every cycle it presents the current fetch address. Unless a branch is taken, it moves the address forward by one at each clock edge. The core's execute stage can ask for an unconditional jump. The jump target takes its low 11 bits from the instruction's immediate. Its top two bits come from bits 4:3 of a small page register, which software loads through a dedicated write port.

The execute stage can also ask for a skip. In that case the address keeps counting, but the instruction already fetched is turned into a no-operation. A jump squashes its following fetch in the same way, so a jump and a taken skip each cost two cycles. A registered flag travels beside each fetched instruction into decode. The flag is low for a squashed slot, and the core must then suppress every write. Requests that arrive while the flag is low belong to a squashed slot and have no effect.

Top module: `pc_seq`

## Requirements
- R1: While reset is asserted (rst_n low), fetch_addr is 0x0000, page_q is 0 and issue_valid is 0. At the first clock edge after release, issue_valid rises to 1, which marks the fetch from address 0 as valid.
- R2: At each clock edge with no accepted jump, fetch_addr becomes its previous value plus one.
- R3: A sequential step from 0x1FFF gives 0x0000.
- R4: An accepted jump sets fetch_addr to {page_q[4:3], jump_imm[10:0]} at the next edge. page_q[4:3] gives address bits 12:11 and the immediate gives bits 10:0.
- R5: After an accepted jump, issue_valid is 0 for exactly one cycle and then returns to 1, so the jump takes two cycles.
- R6: An accepted skip lets fetch_addr step by one as usual and drives issue_valid to 0 for exactly one cycle.
- R7: A request is accepted only while issue_valid is 1. A jump_req or skip_req raised while issue_valid is 0 has no effect: fetch_addr still steps by one and issue_valid returns to 1.
- R8: page_q takes page_d at an edge where page_we is 1, and otherwise keeps its value. A jump does not change it.
- R9: A jump accepted at the same edge as a page write uses the old page_q value. The new value applies from the next jump on.
- R10: While issue_valid is 1 and neither request is raised, issue_valid stays 1.
- R11: If jump_req and skip_req are both accepted at the same edge, the jump target is loaded and only one slot is squashed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jump_req | input | 1 | Execute stage requests an unconditional jump |
| jump_imm | input | 11 | Jump immediate, becomes address bits 10:0 |
| skip_req | input | 1 | Execute stage requests that the next instruction be skipped |
| page_we | input | 1 | Write enable of the page register |
| page_d | input | 5 | Data written into the page register |
| fetch_addr | output | 13 | Current instruction fetch address |
| issue_valid | output | 1 | The instruction now entering decode is real (1) or squashed (0) |
| page_q | output | 5 | Current page register value |

## Verification
Two events can meet at one edge. The first is a jump together with a page register write: the bench writes a new page value in the same cycle as a jump. It checks that the target takes the old page bits, that page_q shows the new value, and that a later jump uses the new value. The second is a jump together with a skip: the bench checks that the target wins and that issue_valid stays low for exactly one cycle. Requests raised in a squashed slot are also driven, to confirm they are dropped.

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int ADDR_W  = 13,
  parameter int IMM_W   = 11,
  parameter int PAGE_W  = 5,
  parameter int PAGE_LO = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jump_req,
  input  logic [IMM_W-1:0]  jump_imm,
  input  logic              skip_req,
  input  logic              page_we,
  input  logic [PAGE_W-1:0] page_d,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              issue_valid,
  output logic [PAGE_W-1:0] page_q
);
  localparam int HI_W = ADDR_W - IMM_W;

  logic              take_jump, take_skip;
  logic [ADDR_W-1:0] next_pc;

  assign take_jump = jump_req & issue_valid;
  assign take_skip = skip_req & issue_valid;
  assign next_pc   = take_jump ? {page_q[PAGE_LO+HI_W-1:PAGE_LO], jump_imm}
                               : fetch_addr + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_addr  <= '0;
      issue_valid <= 1'b0;
      page_q      <= '0;
    end else begin
      fetch_addr  <= next_pc;
      issue_valid <= ~(take_jump | take_skip);
      if (page_we) page_q <= page_d;
    end
  end
endmodule

module pc_seq_chk #(
  parameter int ADDR_W  = 13,
  parameter int IMM_W   = 11,
  parameter int PAGE_W  = 5,
  parameter int PAGE_LO = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              jump_req,
  input logic [IMM_W-1:0]  jump_imm,
  input logic              skip_req,
  input logic              page_we,
  input logic [PAGE_W-1:0] page_d,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              issue_valid,
  input logic [PAGE_W-1:0] page_q
);
  localparam int HI_W = ADDR_W - IMM_W;

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_valid && jump_req) |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1));

  a_r4_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && jump_req) |=>
      fetch_addr == {$past(page_q[PAGE_LO+HI_W-1:PAGE_LO]), $past(jump_imm)});

  a_r5_squash: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && (jump_req || skip_req)) |=> !issue_valid);

  a_r7_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> issue_valid);

  a_r10_stay_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !jump_req && !skip_req) |=> issue_valid);

  a_r8_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !page_we |=> $stable(page_q));

  a_r8_page_load: assert property (@(posedge clk) disable iff (!rst_n)
    page_we |=> page_q == $past(page_d));
endmodule

bind pc_seq pc_seq_chk #(
  .ADDR_W(ADDR_W), .IMM_W(IMM_W), .PAGE_W(PAGE_W), .PAGE_LO(PAGE_LO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .jump_req(jump_req), .jump_imm(jump_imm),
  .skip_req(skip_req), .page_we(page_we), .page_d(page_d),
  .fetch_addr(fetch_addr), .issue_valid(issue_valid), .page_q(page_q)
);

// File: tb/tb_pc_seq.sv
module tb_pc_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        jump_req = 1'b0;
  logic [10:0] jump_imm = '0;
  logic        skip_req = 1'b0;
  logic        page_we = 1'b0;
  logic [4:0]  page_d = '0;
  logic [12:0] fetch_addr;
  logic        issue_valid;
  logic [4:0]  page_q;

  int runs = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pc_seq dut (
    .clk(clk), .rst_n(rst_n), .jump_req(jump_req), .jump_imm(jump_imm),
    .skip_req(skip_req), .page_we(page_we), .page_d(page_d),
    .fetch_addr(fetch_addr), .issue_valid(issue_valid), .page_q(page_q)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    jump_req = 0; skip_req = 0; page_we = 0;
    tick();
  endtask

  task automatic t_reset();
    rst_n = 0;
    tick(); tick();
    check("R1 addr", fetch_addr, 0);
    check("R1 page", page_q, 0);
    check("R1 valid", issue_valid, 0);
    rst_n = 1;
    tick();
    check("R1 first valid", issue_valid, 1);
    check("R2 first step", fetch_addr, 1);
  endtask

  task automatic t_sequential();
    for (int i = 0; i < 4; i++) begin
      logic [12:0] prev = fetch_addr;
      idle();
      check("R2 step", fetch_addr, 13'(prev + 1));
      check("R10 valid held", issue_valid, 1);
    end
  endtask

  task automatic t_jump();
    page_we = 1; page_d = 5'b10110;
    tick(); page_we = 0;
    check("R8 page load", page_q, 5'b10110);
    jump_req = 1; jump_imm = 11'h123;
    tick(); jump_req = 0;
    check("R4 target", fetch_addr, 13'h1123);
    check("R5 squash", issue_valid, 0);
    check("R8 page kept on jump", page_q, 5'b10110);
    idle();
    check("R5 resume valid", issue_valid, 1);
    check("R5 resume addr", fetch_addr, 13'h1124);
  endtask

  task automatic t_ignored();
    jump_req = 1; jump_imm = 11'h200;
    tick();
    check("R4 target", fetch_addr, 13'h1200);
    jump_imm = 11'h055; skip_req = 1;
    tick(); jump_req = 0; skip_req = 0;
    check("R7 ignored jump addr", fetch_addr, 13'h1201);
    check("R7 ignored valid", issue_valid, 1);
    idle();
    check("R7 no late squash", issue_valid, 1);
  endtask

  task automatic t_skip();
    logic [12:0] prev = fetch_addr;
    skip_req = 1;
    tick(); skip_req = 0;
    check("R6 skip addr", fetch_addr, 13'(prev + 1));
    check("R6 skip squash", issue_valid, 0);
    idle();
    check("R6 skip resume", issue_valid, 1);
    check("R6 skip resume addr", fetch_addr, 13'(prev + 2));
  endtask

  task automatic t_wrap();
    page_we = 1; page_d = 5'b11000;
    tick(); page_we = 0;
    jump_req = 1; jump_imm = 11'h7FF;
    tick(); jump_req = 0;
    check("R4 top address", fetch_addr, 13'h1FFF);
    idle();
    check("R3 wrap", fetch_addr, 13'h0000);
    check("R3 valid", issue_valid, 1);
  endtask

  task automatic t_same_cycle();
    page_we = 1; page_d = 5'b01000;
    jump_req = 1; jump_imm = 11'h010;
    tick(); page_we = 0; jump_req = 0;
    check("R9 old page used", fetch_addr, 13'h1810);
    check("R9 page written", page_q, 5'b01000);
    idle();
    jump_req = 1; jump_imm = 11'h033;
    tick(); jump_req = 0;
    check("R9 new page next jump", fetch_addr, 13'h0833);
    idle();
  endtask

  task automatic t_both();
    jump_req = 1; skip_req = 1; jump_imm = 11'h444;
    tick(); jump_req = 0; skip_req = 0;
    check("R11 jump wins", fetch_addr, 13'h0C44);
    check("R11 squash", issue_valid, 0);
    idle();
    check("R11 single squash", issue_valid, 1);
    check("R11 resume addr", fetch_addr, 13'h0C45);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_sequential();
    t_jump();
    t_ignored();
    t_skip();
    t_wrap();
    t_same_cycle();
    t_both();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule